// File: doc/BRIEF.md
# Burst DMA Request/Acknowledge Handshake

This block is the slave side of a DMA link between an external DMA master and an internal word buffer. Software loads a byte count together with a configuration word: enable, burst size, direction and the active levels of the three handshake pins. The block then raises a request to the master. Each cycle in which the master acknowledges while the request is up moves one 16-bit word, and the block pulses a buffer strobe on the side chosen by the direction bit.

The request drops after the last acknowledged word of each burst. It comes back after one idle cycle for as long as bytes remain. A short final burst is requested when the remainder is smaller than a full burst. The transfer ends when the byte count runs out or when the external end-of-transfer pin becomes active. Either ending clears the enable and sets a sticky completion flag. Software can also stop the transfer at any time by writing enable low, and that does not set the flag.

Top module: `dma_burst_hs`

## Requirements
- R1: While enabled with bytes remaining, the request becomes active one cycle after the enable takes effect. It goes inactive in the cycle after the last acknowledged word of a burst. It stays inactive for at least one cycle before the next burst.
- R2: The burst-size field sets how many acknowledged words a request covers: 2'b00 is 1 word, 2'b01 is 4 words, 2'b10 is 8 words, and the reserved code 2'b11 behaves as 1 word. The last burst may be shorter and covers the words that remain.
- R3: An acknowledge counts only in a cycle where the block is enabled and its request is active. Each counted acknowledge gives one buffer strobe and lowers the remaining count by 2 bytes. When 1 byte remains, the count drops to 0.
- R4: An acknowledge given while the block is disabled or its request is inactive gives no strobe and leaves the remaining count unchanged.
- R5: When a counted acknowledge takes the remaining count to 0, the enable clears and the completion flag sets on the same clock edge.
- R6: The end-of-transfer pin, sampled while enabled, clears the enable and sets the completion flag on the next edge. Its active level is the configured one (1 = high, 0 = low), and the opposite level has no effect.
- R7: A configuration write with enable 0 stops the transfer at once. The remaining count is kept and the completion flag is not set.
- R8: The request pin level is set by the request-polarity bit (1 = active high, 0 = active low). The acknowledge pin uses its own polarity bit in the same way. While the block is disabled, the request pin is held at its inactive level.
- R9: With direction 0 every counted word pulses `buf_rd`. With direction 1 it pulses `buf_wr`. The other strobe stays low.
- R10: A configuration write with enable 1 and a byte count of 0 leaves the block disabled and sets the completion flag.
- R11: After reset the block is disabled, the flag is clear, the remaining count is 0 and the polarities are request high, acknowledge low and end-of-transfer low. The flag holds until a `flag_clr` pulse. A new set event wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe; latches every cfg_* field |
| cfg_enable | input | 1 | 1 starts a transfer (loads count), 0 stops one |
| cfg_burst | input | 2 | Burst-size code |
| cfg_dir | input | 1 | 0: buffer read strobes, 1: buffer write strobes |
| cfg_req_pol | input | 1 | Active level of `dreq` |
| cfg_ack_pol | input | 1 | Active level of `dack` |
| cfg_eot_pol | input | 1 | Active level of `eot_in` |
| cfg_count | input | 16 | Transfer length in bytes |
| flag_clr | input | 1 | Clears the completion flag |
| dack | input | 1 | Acknowledge from the DMA master |
| eot_in | input | 1 | External end-of-transfer |
| dreq | output | 1 | Request to the DMA master |
| buf_rd | output | 1 | Word strobe toward the buffer read side |
| buf_wr | output | 1 | Word strobe toward the buffer write side |
| xfer_active | output | 1 | Current enable (self-clearing) |
| done_flag | output | 1 | Sticky completion flag |
| bytes_left | output | 16 | Remaining byte count |

## Verification
A beat counter that is off shows up as a burst of the wrong length, so the master sees the request drop too early or too late within the first burst. A byte counter that is off gives a wrong strobe total, and the enable either clears early or never clears. A polarity or gating fault shows up on `dreq` in the first cycle after a configuration write. An end-of-transfer fault shows on `xfer_active` and `done_flag` one edge after the pin is driven.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  localparam int BEAT_W = 4;

  typedef enum logic [1:0] {
    BL_ONE   = 2'b00,
    BL_FOUR  = 2'b01,
    BL_EIGHT = 2'b10,
    BL_RSVD  = 2'b11
  } burst_code_e;

  // words covered by one request; reserved code falls back to one word
  function automatic logic [BEAT_W-1:0] beats_of(input logic [1:0] code);
    case (burst_code_e'(code))
      BL_FOUR:  beats_of = BEAT_W'(4);
      BL_EIGHT: beats_of = BEAT_W'(8);
      default:  beats_of = BEAT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/dma_byte_ctr.sv
module dma_byte_ctr #(
  parameter int CW         = 16,
  parameter int WORD_BYTES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          fire,
  output logic [CW-1:0] left,
  output logic          final_word
);
  logic [CW-1:0] step;

  // bytes removed by one word, saturating at the remainder
  always_comb step = (left < CW'(WORD_BYTES)) ? left : CW'(WORD_BYTES);

  assign final_word = fire && (left <= CW'(WORD_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    left <= '0;
    else if (load) left <= load_val;
    else if (fire) left <= left - step;
  end

  // R3
  cnt_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> left <= $past(left));
  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !fire) |=> $stable(left));
endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
  import dma_hs_pkg::*;
#(
  parameter int BW = BEAT_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       restart,
  input  logic       fire,
  input  logic       left_nz,
  input  logic       final_word,
  input  logic [1:0] code,
  output logic       req,
  output logic       burst_end
);
  logic [BW-1:0] beat;
  logic [BW-1:0] beats;

  always_comb beats = BW'(beats_of(code));

  assign burst_end = fire && ((beat == beats - 1'b1) || final_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req  <= 1'b0;
      beat <= '0;
    end else if (!en || restart || burst_end) begin
      req  <= 1'b0;
      beat <= '0;
    end else begin
      if (fire)             beat <= beat + 1'b1;
      if (!req && left_nz)  req  <= 1'b1;
    end
  end

  // R1
  burst_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> !req);
  // R2
  beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> beat < beats);
endmodule

// File: rtl/dma_pin_map.sv
module dma_pin_map (
  input  logic req_int,
  input  logic en,
  input  logic dack_pin,
  input  logic eot_pin,
  input  logic req_pol,
  input  logic ack_pol,
  input  logic eot_pol,
  output logic dreq_pin,
  output logic ack_act,
  output logic eot_act
);
  logic req_vis;

  assign req_vis  = req_int & en;
  assign dreq_pin = req_pol ? req_vis : ~req_vis;
  assign ack_act  = (dack_pin == ack_pol);
  assign eot_act  = (eot_pin == eot_pol);
endmodule

// File: rtl/dma_burst_hs.sv
module dma_burst_hs
  import dma_hs_pkg::*;
#(
  parameter int CW         = 16,
  parameter int WORD_BYTES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_enable,
  input  logic [1:0]    cfg_burst,
  input  logic          cfg_dir,
  input  logic          cfg_req_pol,
  input  logic          cfg_ack_pol,
  input  logic          cfg_eot_pol,
  input  logic [CW-1:0] cfg_count,
  input  logic          flag_clr,
  input  logic          dack,
  input  logic          eot_in,
  output logic          dreq,
  output logic          buf_rd,
  output logic          buf_wr,
  output logic          xfer_active,
  output logic          done_flag,
  output logic [CW-1:0] bytes_left
);
  logic       en_q, flag_q, dir_q;
  logic       req_pol_q, ack_pol_q, eot_pol_q;
  logic [1:0] burst_q;

  // named internal events
  logic req, burst_end, final_word;
  logic ack_act, eot_act;
  logic fire, term_int, term_ext, start_zero, flag_set;

  assign fire       = en_q && req && ack_act && !cfg_wr;
  assign term_int   = final_word;
  assign term_ext   = en_q && eot_act && !cfg_wr;
  assign start_zero = cfg_wr && cfg_enable && (cfg_count == '0);
  assign flag_set   = start_zero || term_int || term_ext;

  dma_pin_map u_pins (
    .req_int (req),
    .en      (en_q),
    .dack_pin(dack),
    .eot_pin (eot_in),
    .req_pol (req_pol_q),
    .ack_pol (ack_pol_q),
    .eot_pol (eot_pol_q),
    .dreq_pin(dreq),
    .ack_act (ack_act),
    .eot_act (eot_act)
  );

  dma_byte_ctr #(.CW(CW), .WORD_BYTES(WORD_BYTES)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_wr && cfg_enable),
    .load_val  (cfg_count),
    .fire      (fire),
    .left      (bytes_left),
    .final_word(final_word)
  );

  dma_burst_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_q),
    .restart   (cfg_wr),
    .fire      (fire),
    .left_nz   (bytes_left != '0),
    .final_word(final_word),
    .code      (burst_q),
    .req       (req),
    .burst_end (burst_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      burst_q   <= 2'b00;
      dir_q     <= 1'b0;
      req_pol_q <= 1'b1;
      ack_pol_q <= 1'b0;
      eot_pol_q <= 1'b0;
    end else if (cfg_wr) begin
      en_q      <= cfg_enable && (cfg_count != '0);
      burst_q   <= cfg_burst;
      dir_q     <= cfg_dir;
      req_pol_q <= cfg_req_pol;
      ack_pol_q <= cfg_ack_pol;
      eot_pol_q <= cfg_eot_pol;
    end else if (term_int || term_ext) begin
      en_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_set || (flag_q && !flag_clr);
  end

  assign buf_rd      = fire && !dir_q;
  assign buf_wr      = fire &&  dir_q;
  assign xfer_active = en_q;
  assign done_flag   = flag_q;

  // R5
  count_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_int |=> !xfer_active && done_flag);
  // R6
  eot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_ext |=> !xfer_active && done_flag);
  // R8
  idle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> dreq == !req_pol_q);
  // R4
  no_req_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> !buf_rd && !buf_wr);
  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({buf_rd, buf_wr}) <= 1);
  // R7
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_enable && !flag_q) |=> !done_flag && !xfer_active);
endmodule

// File: tb/dma_burst_hs_bench.sv
module dma_burst_hs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_enable = 1'b0, cfg_dir = 1'b0;
  logic [1:0]  cfg_burst = 2'b00;
  logic        cfg_req_pol = 1'b1, cfg_ack_pol = 1'b0, cfg_eot_pol = 1'b0;
  logic [15:0] cfg_count = '0;
  logic        flag_clr = 1'b0;
  logic        dack = 1'b1, eot_in = 1'b1;
  logic        dreq, buf_rd, buf_wr, xfer_active, done_flag;
  logic [15:0] bytes_left;

  int n_run = 0, n_fail = 0;
  bit done_run = 0;
  logic rp = 1'b1, ap = 1'b0, ep = 1'b0, dirc = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_burst_hs u_dma_burst_hs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_enable(cfg_enable),
    .cfg_burst(cfg_burst), .cfg_dir(cfg_dir), .cfg_req_pol(cfg_req_pol),
    .cfg_ack_pol(cfg_ack_pol), .cfg_eot_pol(cfg_eot_pol), .cfg_count(cfg_count),
    .flag_clr(flag_clr), .dack(dack), .eot_in(eot_in), .dreq(dreq),
    .buf_rd(buf_rd), .buf_wr(buf_wr), .xfer_active(xfer_active),
    .done_flag(done_flag), .bytes_left(bytes_left)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_cfg(input logic en, input logic [1:0] bl, input logic dr,
                        input logic rpo, input logic apo, input logic epo,
                        input int cnt);
    @(negedge clk);
    rp = rpo; ap = apo; ep = epo; dirc = dr;
    dack = !apo; eot_in = !epo;
    cfg_enable = en; cfg_burst = bl; cfg_dir = dr; cfg_req_pol = rpo;
    cfg_ack_pol = apo; cfg_eot_pol = epo; cfg_count = 16'(cnt); cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  // reactive master: acknowledges every cycle the request is visible
  task automatic run_master(output int strobes, output int bursts,
                            output int first_len, output int wrong);
    bit prev = 0;
    int cur = 0;
    strobes = 0; bursts = 0; first_len = 0; wrong = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!xfer_active) break;
      if ((dreq == rp) && !prev) begin
        bursts++;
        if (bursts == 2) first_len = cur;
        cur = 0;
      end
      prev = (dreq == rp);
      dack = (dreq == rp) ? ap : !ap;
      #1;
      if (dirc ? buf_wr : buf_rd) begin strobes++; cur++; end
      if (dirc ? buf_rd : buf_wr) wrong++;
    end
    dack = !ap;
    if (bursts == 1) first_len = cur;
  endtask

  task automatic t_reset();
    chk("R11 reset active", int'(xfer_active), 0);
    chk("R11 reset flag", int'(done_flag), 0);
    chk("R11 reset count", int'(bytes_left), 0);
    chk("R8 reset dreq idle", int'(dreq), 0);
  endtask

  task automatic t_xfer(input logic [1:0] bl, input int cnt, input logic dr);
    int s, b, f, w, words, bw, eb;
    bw = (bl == 2'b01) ? 4 : (bl == 2'b10) ? 8 : 1;
    words = (cnt + 1) / 2;
    eb = (words + bw - 1) / bw;
    do_cfg(1'b1, bl, dr, rp, ap, ep, cnt);
    chk("R1 started", int'(xfer_active), 1);
    run_master(s, b, f, w);
    chk("R3 word strobes", s, words);
    chk("R1 request count", b, eb);
    chk("R2 first burst length", f, (words < bw) ? words : bw);
    chk("R9 other strobe quiet", w, 0);
    chk("R5 enable cleared", int'(xfer_active), 0);
    chk("R5 flag set", int'(done_flag), 1);
    chk("R3 count drained", int'(bytes_left), 0);
    chk("R8 dreq idle after", int'(dreq == rp), 0);
    @(negedge clk);
    chk("R11 flag sticky", int'(done_flag), 1);
    pulse_clr();
    chk("R11 flag cleared", int'(done_flag), 0);
  endtask

  task automatic t_eot();
    do_cfg(1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 64);
    for (int i = 0; i < 10 && dreq != rp; i++) @(negedge clk);
    chk("R1 request up", int'(dreq == rp), 1);
    dack = ap;
    @(negedge clk); @(negedge clk); @(negedge clk);
    dack = !ap;
    chk("R6 inactive eot level ignored", int'(xfer_active), 1);
    eot_in = ep;
    @(negedge clk);
    eot_in = !ep;
    chk("R6 eot stops", int'(xfer_active), 0);
    chk("R6 eot flag", int'(done_flag), 1);
    chk("R6 count kept", int'(bytes_left), 58);
    chk("R8 dreq idle", int'(dreq == rp), 0);
    pulse_clr();
  endtask

  task automatic t_abort_ignore();
    int s = 0;
    do_cfg(1'b1, 2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 100);
    for (int i = 0; i < 10 && dreq != rp; i++) @(negedge clk);
    do_cfg(1'b0, 2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 100);
    chk("R7 abort stops", int'(xfer_active), 0);
    chk("R7 abort no flag", int'(done_flag), 0);
    chk("R7 count kept", int'(bytes_left), 100);
    chk("R8 dreq idle disabled", int'(dreq), 0);
    dack = ap;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      #1;
      if (buf_rd || buf_wr) s++;
    end
    dack = !ap;
    chk("R4 ack ignored strobes", s, 0);
    chk("R4 ack ignored count", int'(bytes_left), 100);
  endtask

  task automatic t_pol();
    do_cfg(1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 0);
    chk("R8 low-active idle high", int'(dreq), 1);
    t_xfer(2'b00, 4, 1'b0);
  endtask

  task automatic t_zero();
    do_cfg(1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 0);
    chk("R10 zero not active", int'(xfer_active), 0);
    chk("R10 zero flag", int'(done_flag), 1);
    chk("R10 zero dreq idle", int'(dreq), 0);
    pulse_clr();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done_run) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_xfer(2'b01, 64, 1'b0);   // 32 words, 8 bursts of 4
    t_xfer(2'b10, 40, 1'b1);   // 20 words, 8+8+4
    t_xfer(2'b00, 6, 1'b0);    // single-word bursts
    t_xfer(2'b11, 8, 1'b1);    // R2 reserved code acts as single
    t_xfer(2'b01, 9, 1'b0);    // odd byte count, partial burst
    t_eot();
    t_abort_ignore();
    t_pol();
    t_zero();
    done_run = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule